// File: doc/BRIEF.md
# Table Access Mailbox Responder

This block answers table-read requests that arrive as a dword stream on a data-object write mailbox. It holds a fixed, read-only table with six entries of varying length. Together the entries describe one memory range: a range-descriptor entry, four latency and bandwidth entries, and a memory-type entry. A request names one entry by handle. The block replies on a read mailbox with a response object made of a three-dword header followed by that entry's dwords.

The header carries the total length of the object in dwords and the handle of the entry that follows the requested one. Software walks the whole table by feeding each returned handle back in until it receives the all-ones terminator. A request object that is too short gets no reply. While a response is pending or being drained, the block reports busy and ignores any new write traffic.

Request format: dword 0 is the object header, dword 1 is the object length, and dword 2 carries the entry handle in bits 31:16. Any dwords after the third are accepted and ignored.

Top module: `table_mbox_responder`

## Requirements
- R1: After reset, `busy` and `rdReady` are both low.
- R2: A request object that ends (`wrLast`) on its first or second dword is discarded. `busy` and `rdReady` stay low and no response appears.
- R3: Response dword 1 holds the object length in dwords. This is 3 plus the entry's byte length divided by four and rounded up. The entry byte lengths are 24, 20, 20, 20, 20 and 26 for handles 0 to 5, giving response lengths 9, 8, 8, 8, 8 and 10.
- R4: Response dword 2 carries the next handle in bits 31:16. It is the requested handle plus one for handles 0 to 4, and 16'hFFFF for handle 5. Bits 15:8 (table type) and 7:0 (response code) are zero.
- R5: Response dword 0 is {8'h00, OBJ_TYPE, VENDOR_ID}, with the vendor ID in bits 15:0 and the object type in bits 23:16.
- R6: Entry payload begins at response dword 3. Each entry's first dword is {byte length[31:16], 8'h00, kind[7:0]}, where kind is 0 for range, 1 for latency/bandwidth and 2 for memory type.
- R7: Entry 0 (range) is: dword 1 = 32'h0000_0400 (non-volatile flag in bit 10, local handle 0); dwords 2 and 3 = base 0 (low, high); dwords 4 and 5 = RANGE_BYTES (low, high).
- R8: Entries 1 to 4 have these fields. Dword 1 = {8'h00, data type, 16'h0000}, where the data type is 0 for read latency, 1 for write latency, 2 for read bandwidth and 3 for write bandwidth. Dwords 2 and 3 = a 64-bit base unit of 10000 for latency and 1000 for bandwidth. Dword 4 = value 15, 25, 16 and 16 respectively, in bits 15:0.
- R9: Entry 5 (memory type) is: dword 1 = {8'h00, 8'd2 attribute, 16'h0000}; dwords 2 and 3 = offset 0; dwords 4 and 5 = RANGE_BYTES; dword 6 = 0 (padding).
- R10: A handle of 6 or above returns a header-only response with length 3 and next handle 16'hFFFF.
- R11: `busy` rises in the cycle after the clock edge that accepts the final request dword, and `rdReady` rises one cycle later. `rdData` shows response dword number N once N pops have been made. Each `rdPop` advances one dword. `rdReady` and `busy` fall in the cycle after the pop of the last dword.
- R12: Write-mailbox traffic while `busy` is high is ignored, so the pending response is unchanged and no second response follows. A request longer than three dwords is answered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write-mailbox dword valid |
| wrData | input | 32 | Write-mailbox dword |
| wrLast | input | 1 | Marks the final dword of a request object |
| busy | output | 1 | A response is being built or drained |
| rdReady | output | 1 | The whole response is loaded in the read mailbox |
| rdData | output | 32 | Current read-mailbox dword |
| rdPop | input | 1 | Consume the current read-mailbox dword |

## Verification
The bench drives each request dword at a falling edge. It expects `busy` high and `rdReady` low at the first falling edge after the edge that takes the final dword, and `rdReady` high at the next falling edge. It checks exactly those cycles.

A monitor pops one dword per cycle while `rdReady` is high and compares each one against a queue of expected dwords that the driver fills from the requirements. A dword that arrives with no queued expectation therefore fails, and so does `rdReady` dropping while expectations remain. For discarded requests and requests ignored while busy, the bench watches `busy` and `rdReady` for several cycles after the stimulus.

// File: rtl/tamr_pkg.sv
package tamr_pkg;
  localparam int DW          = 32;
  localparam int HANDLE_W    = 16;
  localparam int HDR_DW      = 3;
  localparam int REQ_DW      = 3;
  localparam int NUM_ENT     = 6;
  localparam int MAX_ENT_DW  = 7;
  localparam int MAX_RESP_DW = HDR_DW + MAX_ENT_DW;
  localparam int IDX_W       = $clog2(MAX_RESP_DW + 1);
  localparam logic [HANDLE_W-1:0] HANDLE_END = '1;

  localparam logic [7:0] KIND_RANGE = 8'd0;
  localparam logic [7:0] KIND_PERF  = 8'd1;
  localparam logic [7:0] KIND_MTYPE = 8'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_BUILD, ST_HOLD} tamrState_e;

  typedef struct packed {
    logic acceptWr;
    logic objEnd;
    logic build;
    logic pop;
  } tamrStrobes_t;
endpackage

// File: rtl/tamr_ctrl.sv
module tamr_ctrl
  import tamr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrValid,
  input  logic         wrLast,
  input  logic         rdPop,
  input  logic         reqOk,
  input  logic         lastWord,
  output tamrStrobes_t strb,
  output logic         busy,
  output logic         rdReady
);
  tamrState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.acceptWr = wrValid;
        strb.objEnd   = wrValid && wrLast;
        if (wrValid && wrLast && reqOk) stateNext = ST_BUILD;
      end
      ST_BUILD: begin
        strb.build = 1'b1;
        stateNext  = ST_HOLD;
      end
      ST_HOLD: begin
        strb.pop = rdPop;
        if (rdPop && lastWord) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy    = (state != ST_IDLE);
  assign rdReady = (state == ST_HOLD);

  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wrValid && wrLast && !reqOk) |=> !busy); // R2
  AST_READY_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wrValid && wrLast && reqOk) |=> (busy && !rdReady) ##1 rdReady); // R11
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReady && rdPop && lastWord) |=> (!rdReady && !busy)); // R11
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReady && !(rdPop && lastWord)) |=> rdReady); // R12
endmodule

// File: rtl/tamr_datapath.sv
module tamr_datapath
  import tamr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [7:0]  OBJ_TYPE    = 8'h02,
  parameter logic [63:0] RANGE_BYTES = 64'h0000_0002_4000_0000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  tamrStrobes_t  strb,
  input  logic [DW-1:0] wrData,
  output logic          reqOk,
  output logic          lastWord,
  output logic [DW-1:0] rdData
);
  localparam int CNT_W = $clog2(REQ_DW + 1);

  logic [CNT_W-1:0]    wrCnt;
  logic [HANDLE_W-1:0] reqHandle;
  logic [HANDLE_W-1:0] nextHandle;
  logic [IDX_W-1:0]    respLen;
  logic [IDX_W-1:0]    rdIdx;
  logic [15:0]         entBytes;
  logic [15:0]         entDwords;

  function automatic logic [15:0] entryBytes(input logic [HANDLE_W-1:0] h);
    if (h == 16'd0)       return 16'd24;
    else if (h <= 16'd4)  return 16'd20;
    else if (h == 16'd5)  return 16'd26;
    else                  return 16'd0;
  endfunction

  function automatic logic [DW-1:0] entryWord(input logic [HANDLE_W-1:0] h,
                                              input logic [IDX_W-1:0] k);
    logic [DW-1:0] w;
    logic [31:0]   unit;
    logic [15:0]   val;
    w    = '0;
    unit = (h <= 16'd2) ? 32'd10000 : 32'd1000;
    val  = (h == 16'd1) ? 16'd15 : (h == 16'd2) ? 16'd25 : 16'd16;
    if (h == 16'd0) begin
      case (k)
        4'd0: w = {entryBytes(h), 8'h00, KIND_RANGE};
        4'd1: w = 32'h0000_0400;
        4'd4: w = RANGE_BYTES[31:0];
        4'd5: w = RANGE_BYTES[63:32];
        default: w = '0;
      endcase
    end else if (h <= 16'd4) begin
      case (k)
        4'd0: w = {entryBytes(h), 8'h00, KIND_PERF};
        4'd1: w = {8'h00, h[7:0] - 8'd1, 16'h0000};
        4'd2: w = unit;
        4'd4: w = {16'h0000, val};
        default: w = '0;
      endcase
    end else if (h == 16'd5) begin
      case (k)
        4'd0: w = {entryBytes(h), 8'h00, KIND_MTYPE};
        4'd1: w = {8'h00, 8'd2, 16'h0000};
        4'd4: w = RANGE_BYTES[31:0];
        4'd5: w = RANGE_BYTES[63:32];
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  // request side
  assign reqOk = (int'(wrCnt) >= REQ_DW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrCnt     <= '0;
      reqHandle <= '0;
    end else begin
      if (strb.acceptWr && wrCnt == CNT_W'(REQ_DW - 1))
        reqHandle <= wrData[31:16];
      if (strb.objEnd)
        wrCnt <= '0;
      else if (strb.acceptWr && wrCnt != CNT_W'(REQ_DW))
        wrCnt <= wrCnt + 1'b1;
    end
  end

  // response build and drain
  assign entBytes  = entryBytes(reqHandle);
  assign entDwords = (entBytes + 16'd3) >> 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respLen    <= '0;
      nextHandle <= '0;
      rdIdx      <= '0;
    end else if (strb.build) begin
      respLen    <= IDX_W'(HDR_DW) + entDwords[IDX_W-1:0];
      nextHandle <= (reqHandle < 16'(NUM_ENT - 1)) ? reqHandle + 1'b1 : HANDLE_END;
      rdIdx      <= '0;
    end else if (strb.pop) begin
      rdIdx <= rdIdx + 1'b1;
    end
  end

  assign lastWord = (rdIdx == respLen - 1'b1);

  always_comb begin
    unique case (rdIdx)
      4'd0:    rdData = {8'h00, OBJ_TYPE, VENDOR_ID};
      4'd1:    rdData = DW'(respLen);
      4'd2:    rdData = {nextHandle, 8'h00, 8'h00};
      default: rdData = entryWord(reqHandle, rdIdx - IDX_W'(HDR_DW));
    endcase
  end

  AST_NEXT_END: assert property (@(posedge clk) disable iff (!rst_n)
    strb.build |=> ((nextHandle == HANDLE_END) == ($past(reqHandle) >= 16'(NUM_ENT - 1)))); // R4
  AST_NEXT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.build && reqHandle < 16'(NUM_ENT - 1)) |=> nextHandle == $past(reqHandle) + 1'b1); // R4
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.build |=> (respLen >= IDX_W'(HDR_DW) && respLen <= IDX_W'(MAX_RESP_DW))); // R3
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> rdIdx < respLen); // R11
  AST_WR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    strb.acceptWr |-> !$isunknown(wrData)); // R12
endmodule

// File: rtl/table_mbox_responder.sv
module table_mbox_responder
  import tamr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [7:0]  OBJ_TYPE    = 8'h02,
  parameter logic [63:0] RANGE_BYTES = 64'h0000_0002_4000_0000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          wrLast,
  output logic          busy,
  output logic          rdReady,
  output logic [DW-1:0] rdData,
  input  logic          rdPop
);
  tamrStrobes_t strb;
  logic         reqOk;
  logic         lastWord;

  tamr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrValid  (wrValid),
    .wrLast   (wrLast),
    .rdPop    (rdPop),
    .reqOk    (reqOk),
    .lastWord (lastWord),
    .strb     (strb),
    .busy     (busy),
    .rdReady  (rdReady)
  );

  tamr_datapath #(
    .VENDOR_ID   (VENDOR_ID),
    .OBJ_TYPE    (OBJ_TYPE),
    .RANGE_BYTES (RANGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wrData   (wrData),
    .reqOk    (reqOk),
    .lastWord (lastWord),
    .rdData   (rdData)
  );
endmodule

// File: tb/table_mbox_responder_bench.sv
module table_mbox_responder_bench;
  localparam logic [15:0] VID   = 16'h1A2B;
  localparam logic [7:0]  OTYPE = 8'h02;
  localparam logic [63:0] RSIZE = 64'h0000_0002_4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        wrLast = 1'b0;
  logic        rdPop = 1'b0;
  logic        busy, rdReady;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  table_mbox_responder #(.VENDOR_ID(VID), .OBJ_TYPE(OTYPE), .RANGE_BYTES(RSIZE))
    u_table_mbox_responder (
      .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
      .wrLast(wrLast), .busy(busy), .rdReady(rdReady), .rdData(rdData),
      .rdPop(rdPop));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int entLen(input int h);
    if (h == 0) return 24;
    if (h >= 1 && h <= 4) return 20;
    if (h == 5) return 26;
    return 0;
  endfunction

  // Entry dword k of handle h, as stated in R6..R9
  function automatic logic [31:0] entWord(input int h, input int k);
    logic [31:0] kind;
    kind = (h == 0) ? 32'd0 : (h == 5) ? 32'd2 : 32'd1;
    if (k == 0) return (32'(entLen(h)) << 16) | kind;
    if (h == 0) begin
      if (k == 1) return 32'h0000_0400;
      if (k == 4) return RSIZE[31:0];
      if (k == 5) return RSIZE[63:32];
      return 32'h0;
    end
    if (h == 5) begin
      if (k == 1) return 32'h0002_0000;
      if (k == 4) return RSIZE[31:0];
      if (k == 5) return RSIZE[63:32];
      return 32'h0;
    end
    if (k == 1) return 32'(h - 1) << 16;
    if (k == 2) return (h <= 2) ? 32'd10000 : 32'd1000;
    if (k == 4) return (h == 1) ? 32'd15 : (h == 2) ? 32'd25 : 32'd16;
    return 32'h0;
  endfunction

  task automatic pushExpected(input int h);
    int nEnt;
    string etag;
    nEnt = (entLen(h) + 3) / 4;
    etag = (h == 0) ? "R7" : (h == 5) ? "R9" : "R8";
    expQ.push_back({8'h00, OTYPE, VID});               tagQ.push_back("R5");
    expQ.push_back(32'(3 + nEnt));                     tagQ.push_back((h > 5) ? "R10" : "R3");
    expQ.push_back({(h < 5) ? 16'(h + 1) : 16'hFFFF, 16'h0000});
    tagQ.push_back((h > 5) ? "R10" : "R4");
    for (int k = 0; k < nEnt; k++) begin
      expQ.push_back(entWord(h, k));
      tagQ.push_back((k == 0) ? "R6" : etag);
    end
  endtask

  function automatic logic [31:0] reqDword(input int h, input int i);
    if (i == 0) return {8'h00, OTYPE, VID};
    if (i == 1) return 32'd3;
    if (i == 2) return {16'(h), 16'h0000};
    return 32'hDEAD_BEEF;
  endfunction

  task automatic sendReq(input int h, input int ndw);
    if (ndw >= 3) pushExpected(h);
    for (int i = 0; i < ndw; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrData  = reqDword(h, i);
      wrLast  = (i == ndw - 1);
    end
    @(negedge clk);
    wrValid = 1'b0;
    wrLast  = 1'b0;
    if (ndw >= 3) begin
      chk(busy && !rdReady, "R11 busy before ready", {30'h0, busy, rdReady}, 32'h2);
      @(negedge clk);
      chk(rdReady, "R11 ready latency", {31'h0, rdReady}, 32'h1);
    end else begin
      for (int c = 0; c < 3; c++) begin
        chk(!busy && !rdReady, "R2 short request dropped", {30'h0, busy, rdReady}, 32'h0);
        @(negedge clk);
      end
    end
  endtask

  task automatic waitDone();
    while (rdReady || expQ.size() != 0) @(negedge clk);
    chk(!busy, "R11 busy clears with ready", {31'h0, busy}, 32'h0);
  endtask

  // Monitor: pops one dword per cycle while ready, compares against the queue
  initial begin
    forever begin
      @(negedge clk);
      rdPop = 1'b0;
      if (rst_n && rdReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R11 unexpected extra dword", rdData, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(rdData === e, t, rdData, e);
        end
        rdPop = 1'b1;
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rdReady, "R1 reset state", {30'h0, busy, rdReady}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rdReady, "R1 after reset release", {30'h0, busy, rdReady}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int h = 0; h < 6; h++) begin
      sendReq(h, 3);
      waitDone();
    end
    // out-of-range handles: R10
    sendReq(6, 3);      waitDone();
    sendReq(16'h1234, 3); waitDone();
    // short objects: R2
    sendReq(3, 1);
    sendReq(3, 2);
    // over-long object answered normally: R12
    sendReq(2, 4);
    waitDone();
    // writes while busy ignored: R12
    sendReq(1, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrData  = reqDword(5, i);
      wrLast  = (i == 2);
    end
    @(negedge clk);
    wrValid = 1'b0;
    wrLast  = 1'b0;
    waitDone();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!busy && !rdReady, "R12 no response to busy-time write",
          {30'h0, busy, rdReady}, 32'h0);
    end
    // a following request still works after the ignored one: R12
    sendReq(4, 3);
    waitDone();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule